// File: doc/BRIEF.md
# LVT-Based Multi-Ported Register Memory

This block is a memory with several write ports and several read ports. All ports work in the same clock cycle. It is built only from storage arrays that have one write port and one read port each, so an FPGA tool can map every array to block RAM. Each write port owns a group of arrays. The group holds one copy of the data for every read port, so each array sees exactly one writer and one reader.

Because each write port writes only its own group, a given address can hold valid data in any of the groups. A narrow table, kept in flip-flops and indexed by address, records which write port touched each location most recently. Every read port looks up its address in this table. One cycle later it uses the stored port number to choose which group's copy becomes its read data. To the user, the write-banked storage then behaves as a single coherent memory.

The block suits register files and shared queues inside parallel datapaths. These need several independent accesses per cycle and cannot accept the lower clock rate of time-multiplexing a single RAM.

Top module: `lvt_mpram`

## Requirements
- R1: Read data appears one clock after the read address is sampled on a rising edge.
  - It is the word most recently written to that address.
  - Read port p uses address bits [p*ADDR_W +: ADDR_W] and data bits [p*DATA_W +: DATA_W].
  - Write port p uses wr_en bit p, the same address slice and the same data slice.
- R2: A write by port i records i as the owner of that address. Later reads of that address return port i's data. With 2 write ports: port 0 writes 0x42 to one address and port 1 writes 0x23 to another. Reads then return 0x42 and 0x23 respectively.
- R3: In one cycle, every write port may write a different address and every read port may read any address. Each read returns the correct data.
- R4: If no write occurs and a read address stays constant, that port's read data stays constant.
- R5: When several write ports write the same address in the same cycle, the highest-numbered port wins. Its data is what every later read returns.
- R6: Reset sets every table entry to port 0 and leaves the arrays untouched. A location read after reset therefore returns the last data written to it by port 0.
- R7: A read of an address that is being written in the same cycle returns the value held before that write.
- R8: While reset is asserted, every read data output is zero from the first clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock; all activity on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | WR_PORTS | Write enable, one bit per write port |
| wr_addr | input | WR_PORTS*ADDR_W | Packed write addresses |
| wr_data | input | WR_PORTS*DATA_W | Packed write data |
| rd_addr | input | RD_PORTS*ADDR_W | Packed read addresses, sampled every cycle |
| rd_data | output | RD_PORTS*DATA_W | Packed read data, one cycle after the address |

## Verification
A write and a read of the same address can fall in the same cycle, and so can two writes to one address. The bench provokes the first case by reading, on both ports, an address that port 0 is writing in that cycle. It expects the old word, then the new word one cycle later. It provokes the second case with both ports writing one address. It expects port 1's data on every later read. All results are judged against a model kept per write group, which follows the same rules.

// File: rtl/lvt_mpram_pkg.sv
package lvt_mpram_pkg;
  // width of a write-port index; at least one bit so vectors stay legal
  function automatic int port_idx_w(input int ports);
    return (ports > 1) ? $clog2(ports) : 1;
  endfunction
endpackage

// File: rtl/sdp_bank.sv
module sdp_bank #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  // write side: no reset, so the array maps to block RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // synchronous read, old data on a same-address collision
  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= mem[raddr];
  end
endmodule

// File: rtl/lvt_table.sv
module lvt_table #(
  parameter int WR_PORTS = 2,
  parameter int RD_PORTS = 2,
  parameter int DEPTH    = 16,
  parameter int ADDR_W   = 4,
  parameter int SEL_W    = 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [WR_PORTS-1:0]        we,
  input  logic [WR_PORTS*ADDR_W-1:0] waddr,
  input  logic [RD_PORTS*ADDR_W-1:0] raddr,
  output logic [RD_PORTS*SEL_W-1:0]  rsel
);
  logic [SEL_W-1:0]  tbl [DEPTH];
  logic [ADDR_W-1:0] wa  [WR_PORTS];
  logic [ADDR_W-1:0] ra  [RD_PORTS];

  for (genvar p = 0; p < WR_PORTS; p++) begin : g_wa
    assign wa[p] = waddr[p*ADDR_W +: ADDR_W];
  end
  for (genvar r = 0; r < RD_PORTS; r++) begin : g_ra
    assign ra[r] = raddr[r*ADDR_W +: ADDR_W];
  end

  // ascending port order: the last nonblocking update wins, so the
  // highest-numbered port owns a contested address
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int a = 0; a < DEPTH; a++) tbl[a] <= '0;
    end else begin
      for (int p = 0; p < WR_PORTS; p++)
        if (we[p]) tbl[wa[p]] <= SEL_W'(p);
    end
  end

  // lookup registered to line up with the bank read register
  always_ff @(posedge clk) begin
    for (int r = 0; r < RD_PORTS; r++) begin
      if (rst) rsel[r*SEL_W +: SEL_W] <= '0;
      else     rsel[r*SEL_W +: SEL_W] <= tbl[ra[r]];
    end
  end

  // assertion support: port p loses to a higher port on the same address
  logic [WR_PORTS-1:0] beaten;
  logic                any_set;
  always_comb begin
    beaten = '0;
    for (int p = 0; p < WR_PORTS; p++)
      for (int q = p + 1; q < WR_PORTS; q++)
        if (we[p] && we[q] && (wa[p] == wa[q])) beaten[p] = 1'b1;
  end
  always_comb begin
    any_set = 1'b0;
    for (int a = 0; a < DEPTH; a++) any_set = any_set | (|tbl[a]);
  end

  p_lvt_clear_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !any_set);

  for (genvar p = 0; p < WR_PORTS; p++) begin : g_chk
    p_lvt_owner_r2: assert property (@(posedge clk) disable iff (rst)
      (we[p] && !beaten[p]) |=> (tbl[$past(wa[p])] == SEL_W'(p)));
    p_lvt_conflict_r5: assert property (@(posedge clk) disable iff (rst)
      (we[p] && beaten[p]) |=> (tbl[$past(wa[p])] != SEL_W'(p)));
  end
endmodule

// File: rtl/lvt_mpram.sv
module lvt_mpram
  import lvt_mpram_pkg::*;
#(
  parameter int WR_PORTS = 2,
  parameter int RD_PORTS = 2,
  parameter int DEPTH    = 16,
  parameter int DATA_W   = 8,
  localparam int ADDR_W  = $clog2(DEPTH)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [WR_PORTS-1:0]        wr_en,
  input  logic [WR_PORTS*ADDR_W-1:0] wr_addr,
  input  logic [WR_PORTS*DATA_W-1:0] wr_data,
  input  logic [RD_PORTS*ADDR_W-1:0] rd_addr,
  output logic [RD_PORTS*DATA_W-1:0] rd_data
);
  localparam int SEL_W = port_idx_w(WR_PORTS);

  logic [DATA_W-1:0]        bank_q [WR_PORTS][RD_PORTS];
  logic [RD_PORTS*SEL_W-1:0] sel;

  // one copy per (write group, read port)
  for (genvar w = 0; w < WR_PORTS; w++) begin : g_grp
    for (genvar r = 0; r < RD_PORTS; r++) begin : g_copy
      sdp_bank #(
        .DEPTH (DEPTH),
        .DATA_W(DATA_W),
        .ADDR_W(ADDR_W)
      ) u_bank (
        .clk  (clk),
        .rst  (rst),
        .we   (wr_en[w]),
        .waddr(wr_addr[w*ADDR_W +: ADDR_W]),
        .wdata(wr_data[w*DATA_W +: DATA_W]),
        .raddr(rd_addr[r*ADDR_W +: ADDR_W]),
        .rdata(bank_q[w][r])
      );
    end
  end

  lvt_table #(
    .WR_PORTS(WR_PORTS),
    .RD_PORTS(RD_PORTS),
    .DEPTH   (DEPTH),
    .ADDR_W  (ADDR_W),
    .SEL_W   (SEL_W)
  ) u_lvt (
    .clk  (clk),
    .rst  (rst),
    .we   (wr_en),
    .waddr(wr_addr),
    .raddr(rd_addr),
    .rsel (sel)
  );

  // steering mux after the read registers
  always_comb begin
    rd_data = '0;
    for (int r = 0; r < RD_PORTS; r++)
      for (int w = 0; w < WR_PORTS; w++)
        if (sel[r*SEL_W +: SEL_W] == SEL_W'(w))
          rd_data[r*DATA_W +: DATA_W] = bank_q[w][r];
  end

  // R4: idle memory and steady addresses keep the outputs steady
  p_rd_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2) && ($past(wr_en, 2) == '0) &&
     ($past(rd_addr) == $past(rd_addr, 2))) |-> $stable(rd_data));
endmodule

// File: tb/lvt_mpram_tb.sv
module lvt_mpram_tb;
  localparam int M = 2;
  localparam int N = 2;
  localparam int DEPTH = 16;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 12;

  // {we[1:0], a0, d0, a1, d1, r0, r1}
  localparam logic [33:0] VEC [NV] = '{
    {2'b01, 4'h1, 8'h42, 4'h3, 8'h00, 4'h0, 4'h0},
    {2'b10, 4'h0, 8'h00, 4'h3, 8'h23, 4'h1, 4'h3},
    {2'b00, 4'h0, 8'h00, 4'h0, 8'h00, 4'h3, 4'h1},
    {2'b11, 4'h5, 8'hA5, 4'h6, 8'hB6, 4'h5, 4'h6},
    {2'b11, 4'h7, 8'h17, 4'h8, 8'h28, 4'h5, 4'h6},
    {2'b00, 4'h0, 8'h00, 4'h0, 8'h00, 4'h7, 4'h8},
    {2'b11, 4'h9, 8'h99, 4'h9, 8'hAA, 4'h9, 4'h9},
    {2'b00, 4'h0, 8'h00, 4'h0, 8'h00, 4'h9, 4'h9},
    {2'b01, 4'h6, 8'hC6, 4'h0, 8'h00, 4'h6, 4'h1},
    {2'b00, 4'h0, 8'h00, 4'h0, 8'h00, 4'h6, 4'h3},
    {2'b10, 4'h1, 8'h00, 4'h1, 8'hD1, 4'hF, 4'hE},
    {2'b00, 4'h0, 8'h00, 4'h0, 8'h00, 4'h1, 4'h6}
  };

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [M-1:0]     wr_en = '0;
  logic [M*AW-1:0]  wr_addr = '0;
  logic [M*DW-1:0]  wr_data = '0;
  logic [N*AW-1:0]  rd_addr = '0;
  logic [N*DW-1:0]  rd_data;

  int total = 0;
  int bad = 0;
  logic [DW-1:0] mb0 [DEPTH];
  logic [DW-1:0] mb1 [DEPTH];
  logic          own [DEPTH];

  always #(CLK_PERIOD/2) clk = ~clk;

  lvt_mpram #(.WR_PORTS(M), .RD_PORTS(N), .DEPTH(DEPTH), .DATA_W(DW)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic step(input logic [1:0] we, input logic [3:0] a0, input logic [7:0] d0,
                      input logic [3:0] a1, input logic [7:0] d1,
                      input logic [3:0] r0, input logic [3:0] r1,
                      input string tag, input bit chk);
    logic [DW-1:0] e0, e1;
    wr_en = we; wr_addr = {a1, a0}; wr_data = {d1, d0}; rd_addr = {r1, r0};
    e0 = own[r0] ? mb1[r0] : mb0[r0];
    e1 = own[r1] ? mb1[r1] : mb0[r1];
    if (we[0]) begin mb0[a0] = d0; own[a0] = 1'b0; end
    if (we[1]) begin mb1[a1] = d1; own[a1] = 1'b1; end
    @(posedge clk);
    @(negedge clk);
    if (chk) begin
      check({tag, " port0"}, rd_data[0 +: DW], e0);
      check({tag, " port1"}, rd_data[DW +: DW], e1);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL R1 watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [DW-1:0] h0;
    for (int a = 0; a < DEPTH; a++) own[a] = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R8 reset port0", rd_data[0 +: DW], 8'h00);
    check("R8 reset port1", rd_data[DW +: DW], 8'h00);
    rst = 1'b0;

    // define every location in both groups (port 1 wins, R5)
    for (int a = 0; a < DEPTH; a++)
      step(2'b11, 4'(a), 8'(8'h40 + a), 4'(a), 8'(8'h80 + a), 4'h0, 4'h0, "init", 1'b0);
    step(2'b00, 4'h0, 8'h00, 4'h0, 8'h00, 4'h4, 4'hB, "R5 init", 1'b1);

    // table walk: mixed concurrent traffic
    for (int i = 0; i < NV; i++)
      step(VEC[i][33:32], VEC[i][31:28], VEC[i][27:20], VEC[i][19:16],
           VEC[i][15:8], VEC[i][7:4], VEC[i][3:0], "R1 R3 table", 1'b1);

    // R2: write-port ownership, example values
    step(2'b11, 4'h2, 8'h42, 4'h4, 8'h23, 4'h0, 4'h0, "R2 write", 1'b0);
    step(2'b00, 4'h0, 8'h00, 4'h0, 8'h00, 4'h2, 4'h4, "R2", 1'b0);
    check("R2 port0 gets port-0 data", rd_data[0 +: DW], 8'h42);
    check("R2 port1 gets port-1 data", rd_data[DW +: DW], 8'h23);

    // R5: same-address write conflict
    step(2'b11, 4'hA, 8'h55, 4'hA, 8'h66, 4'h0, 4'h0, "R5 write", 1'b0);
    step(2'b00, 4'h0, 8'h00, 4'h0, 8'h00, 4'hA, 4'hA, "R5", 1'b1);
    check("R5 highest port wins", rd_data[0 +: DW], 8'h66);

    // R7: read during write of the same address
    step(2'b01, 4'hB, 8'h77, 4'h0, 8'h00, 4'hB, 4'hB, "R7 old", 1'b1);
    check("R7 old value", rd_data[DW +: DW], 8'h8B);
    step(2'b00, 4'h0, 8'h00, 4'h0, 8'h00, 4'hB, 4'hB, "R7 new", 1'b1);

    // R4: idle, steady addresses
    step(2'b00, 4'h0, 8'h00, 4'h0, 8'h00, 4'h5, 4'hA, "R4 a", 1'b1);
    h0 = rd_data[0 +: DW];
    step(2'b00, 4'h0, 8'h00, 4'h0, 8'h00, 4'h5, 4'hA, "R4 b", 1'b1);
    check("R4 hold", rd_data[0 +: DW], h0);

    // R6 / R8: reset mid-run keeps arrays, clears ownership
    step(2'b01, 4'hC, 8'h12, 4'h0, 8'h00, 4'h0, 4'h0, "R6 w0", 1'b0);
    step(2'b10, 4'h0, 8'h00, 4'hC, 8'h34, 4'h0, 4'h0, "R6 w1", 1'b0);
    step(2'b00, 4'h0, 8'h00, 4'h0, 8'h00, 4'hC, 4'hC, "R6 before", 1'b1);
    check("R6 before reset", rd_data[0 +: DW], 8'h34);
    wr_en = '0;
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R8 mid reset port0", rd_data[0 +: DW], 8'h00);
    check("R8 mid reset port1", rd_data[DW +: DW], 8'h00);
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    for (int a = 0; a < DEPTH; a++) own[a] = 1'b0;
    step(2'b00, 4'h0, 8'h00, 4'h0, 8'h00, 4'hC, 4'hA, "R6 after", 1'b1);
    check("R6 reads port-0 group", rd_data[0 +: DW], 8'h12);
    check("R6 reads port-0 group", rd_data[DW +: DW], 8'h55);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule